// File: doc/BRIEF.md
# Serial shift interface

This block is a bare serial engine for a small controller. Software uses it to run either a three-wire link with separate data in, data out and clock pins, or a two-wire bus with open-drain data and clock lines. The block holds one shift register that software reads and writes directly, and a small edge counter that tells software when a byte has gone by. In two-wire mode a bus monitor reports start and stop conditions. Addressing, acknowledge bits and arbitration are left to software.

The shift and count clock comes from one of three sources: a strobe that software writes, a timer tick, or the external clock pin. Pins are sampled on the system clock through a synchroniser. The serial output passes through an output latch. With the pin clock selected, the pin changes on the edge opposite to the one that samples data in. Interrupt requests come from the overflow flag and the start flag, each with its own enable.

Register map (2-bit address): 0 is the shift register, 1 is status, 2 is control, and 3 reads as zero. Status bits: [7] start flag, [6] overflow flag, [5] stop flag, [4] collision (live), [3:0] counter. Control bits: [7] start interrupt enable, [6] overflow interrupt enable, [5:4] wire mode (00 off, 01 three-wire, 10 two-wire), [3:2] clock source, [1] shift strobe (write only, reads 0). Reads return data one cycle after the address is presented.

Top module: `ser_shift_if`

## Requirements
- R1: After reset, the shift register, status and control read 0. All pin enables and both interrupt outputs are 0.
- R2: The shift register's MSB reaches `do_o` through the output latch. In three-wire mode (control[5:4]=01) `do_oe` is 1. With a software or timer clock the latch is always open, so `do_o` follows the MSB.
- R3: Each shift event moves the shift register one place toward its MSB and loads the synchronised `di_sda_i` level into bit 0. A write to address 0 loads the register and takes priority over a shift in the same cycle.
- R4: The counter in status[3:0] advances by one on each count event. A write to address 1 loads it from wdata[3:0].
- R5: When a count event moves the counter from 15 to 0, status[6] is set. `irq_ovf` equals status[6] AND control[6]. Writing 1 to status[6] clears it.
- R6: With clock source 10 (sample on rising edge), data shifts on a rising clock-pin edge. `do_o` holds while the clock pin is high and takes the new MSB after the falling edge.
- R7: Clock source control[3:2] selects the shift and count events: 00 is a write of 1 to control[1]; 01 is a `tmr_tick_i` pulse; 10 and 11 use the clock pin, counting both edges and shifting on the rising (10) or falling (11) edge. Events from the sources not selected are ignored.
- R8: In two-wire mode only, a falling data line while the clock line is high sets status[7]. `irq_start` equals status[7] AND control[7]. `scl_oe` holds the clock line low while status[7] or status[6] is set in two-wire mode. Writing 1 to status[7] clears it.
- R9: In two-wire mode only, a rising data line while the clock line is high sets status[5]. It does not hold the clock line and is cleared by writing 1 to it.
- R10: In two-wire mode (control[5:4]=10) the data line is open-drain: `sda_oe` is 1 exactly when the latched output bit is 0, and `do_oe` is 0.
- R11: Status[4] reads 1 while, in two-wire mode, the latched output bit is 1 but the sensed data line is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |
| tmr_tick_i | input | 1 | Timer compare pulse, one cycle |
| di_sda_i | input | 1 | Data-in pin / two-wire data line level |
| sck_scl_i | input | 1 | Clock pin / two-wire clock line level |
| do_o | output | 1 | Three-wire data output |
| do_oe | output | 1 | Data output enable |
| sda_oe | output | 1 | Pull data line low |
| scl_oe | output | 1 | Pull clock line low |
| irq_start | output | 1 | Start-condition interrupt request |
| irq_ovf | output | 1 | Counter overflow interrupt request |

## Verification
The bench builds the block with DATA_W=8, CNT_W=4 and SYNC_STAGES=2. With a 4-bit counter, one full byte on the pin clock (eight pulses, sixteen edges) reaches the overflow, so wraps and interrupt requests appear within short directed runs. The two-stage synchroniser keeps the delay from pin to effect at about three cycles. The bench waits a fixed six cycles after each pin change, which covers this delay and still shows whether the output latch holds or opens on each clock phase.

// File: rtl/ssi_pkg.sv
package ssi_pkg;
  typedef enum logic [1:0] {
    WM_OFF   = 2'b00,
    WM_THREE = 2'b01,
    WM_TWO   = 2'b10,
    WM_RSVD  = 2'b11
  } wire_mode_e;

  typedef enum logic [1:0] {
    CS_SOFT     = 2'b00,
    CS_TIMER    = 2'b01,
    CS_EXT_RISE = 2'b10,
    CS_EXT_FALL = 2'b11
  } clk_src_e;

  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_CTRL = 2'd2;

  localparam int B_START = 7;
  localparam int B_OVF   = 6;
  localparam int B_STOP  = 5;
  localparam int B_COLL  = 4;
  localparam int B_STRB  = 1;
endpackage

// File: rtl/ssi_pin_sync.sv
module ssi_pin_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;
  logic [W-1:0]             prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe_q <= '1;
      prev_q <= '1;
    end else begin
      pipe_q[0] <= pin_i;
      for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
      prev_q <= pipe_q[STAGES-1];
    end
  end

  assign lvl_o  = pipe_q[STAGES-1];
  assign rise_o = pipe_q[STAGES-1] & ~prev_q;
  assign fall_o = ~pipe_q[STAGES-1] & prev_q;
endmodule

// File: rtl/ssi_edge_counter.sv
module ssi_edge_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  always_ff @(posedge clk) begin
    if (rst)         cnt_o <= '0;
    else if (load_i) cnt_o <= load_val_i;
    else if (tick_i) cnt_o <= cnt_o + 1'b1;
  end

  assign wrap_o = tick_i && !load_i && (cnt_o == '1);
endmodule

// File: rtl/ssi_bus_monitor.sv
module ssi_bus_monitor (
  input  logic en_i,
  input  logic scl_lvl_i,
  input  logic sda_rise_i,
  input  logic sda_fall_i,
  output logic start_o,
  output logic stop_o
);
  assign start_o = en_i && scl_lvl_i && sda_fall_i;
  assign stop_o  = en_i && scl_lvl_i && sda_rise_i;
endmodule

// File: rtl/ser_shift_if.sv
module ser_shift_if
  import ssi_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              tmr_tick_i,
  input  logic              di_sda_i,
  input  logic              sck_scl_i,
  output logic              do_o,
  output logic              do_oe,
  output logic              sda_oe,
  output logic              scl_oe,
  output logic              irq_start,
  output logic              irq_ovf
);
  localparam int MSB = DATA_W - 1;

  logic [MSB:0]       data_q;
  logic               out_q;
  logic               start_f, ovf_f, stop_f, coll_q;
  logic               start_ie, ovf_ie, strobe_q;
  wire_mode_e         mode_q;
  clk_src_e           src_q;
  logic [1:0]         pin_s, pin_rise, pin_fall;
  logic               shift_p, cnt_tick, cnt_wrap, latch_open;
  logic               start_det, stop_det;
  logic [CNT_W-1:0]   cnt_val;
  logic [MSB:0]       clr_mask, stat_v, ctrl_v;
  logic               wr_data, wr_stat, wr_ctrl, two_wire;

  assign wr_data  = reg_we && (reg_addr == A_DATA);
  assign wr_stat  = reg_we && (reg_addr == A_STAT);
  assign wr_ctrl  = reg_we && (reg_addr == A_CTRL);
  assign clr_mask = wr_stat ? reg_wdata : '0;
  assign two_wire = (mode_q == WM_TWO);

  // bit 0: data line, bit 1: clock line
  ssi_pin_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .pin_i  ({sck_scl_i, di_sda_i}),
    .lvl_o  (pin_s),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  always_comb begin
    case (src_q)
      CS_SOFT:     begin shift_p = strobe_q;    cnt_tick = strobe_q;    latch_open = 1'b1;      end
      CS_TIMER:    begin shift_p = tmr_tick_i;  cnt_tick = tmr_tick_i;  latch_open = 1'b1;      end
      CS_EXT_RISE: begin shift_p = pin_rise[1]; cnt_tick = pin_rise[1] | pin_fall[1]; latch_open = !pin_s[1]; end
      default:     begin shift_p = pin_fall[1]; cnt_tick = pin_rise[1] | pin_fall[1]; latch_open = pin_s[1];  end
    endcase
  end

  ssi_edge_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .load_i     (wr_stat),
    .load_val_i (reg_wdata[CNT_W-1:0]),
    .tick_i     (cnt_tick),
    .cnt_o      (cnt_val),
    .wrap_o     (cnt_wrap)
  );

  ssi_bus_monitor u_mon (
    .en_i       (two_wire),
    .scl_lvl_i  (pin_s[1]),
    .sda_rise_i (pin_rise[0]),
    .sda_fall_i (pin_fall[0]),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q   <= '0;
      out_q    <= 1'b0;
      start_f  <= 1'b0;
      ovf_f    <= 1'b0;
      stop_f   <= 1'b0;
      coll_q   <= 1'b0;
      start_ie <= 1'b0;
      ovf_ie   <= 1'b0;
      mode_q   <= WM_OFF;
      src_q    <= CS_SOFT;
      strobe_q <= 1'b0;
    end else begin
      if (wr_data)      data_q <= reg_wdata;
      else if (shift_p) data_q <= {data_q[MSB-1:0], pin_s[0]};
      if (latch_open)   out_q  <= data_q[MSB];
      start_f <= start_det | (start_f & ~clr_mask[B_START]);
      ovf_f   <= cnt_wrap  | (ovf_f   & ~clr_mask[B_OVF]);
      stop_f  <= stop_det  | (stop_f  & ~clr_mask[B_STOP]);
      coll_q  <= two_wire && out_q && !pin_s[0];
      if (wr_ctrl) begin
        start_ie <= reg_wdata[B_START];
        ovf_ie   <= reg_wdata[B_OVF];
        mode_q   <= wire_mode_e'(reg_wdata[5:4]);
        src_q    <= clk_src_e'(reg_wdata[3:2]);
      end
      strobe_q <= wr_ctrl && reg_wdata[B_STRB];
    end
  end

  always_comb begin
    stat_v                 = '0;
    stat_v[CNT_W-1:0]      = cnt_val;
    stat_v[B_COLL]         = coll_q;
    stat_v[B_STOP]         = stop_f;
    stat_v[B_OVF]          = ovf_f;
    stat_v[B_START]        = start_f;
    ctrl_v                 = '0;
    ctrl_v[B_START]        = start_ie;
    ctrl_v[B_OVF]          = ovf_ie;
    ctrl_v[5:4]            = mode_q;
    ctrl_v[3:2]            = src_q;
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_addr)
        A_DATA:  reg_rdata <= data_q;
        A_STAT:  reg_rdata <= stat_v;
        A_CTRL:  reg_rdata <= ctrl_v;
        default: reg_rdata <= '0;
      endcase
    end
  end

  assign do_o      = out_q;
  assign do_oe     = (mode_q == WM_THREE);
  assign sda_oe    = two_wire && !out_q;
  assign scl_oe    = two_wire && (start_f || ovf_f);
  assign irq_start = start_f && start_ie;
  assign irq_ovf   = ovf_f && ovf_ie;
endmodule

// File: rtl/ssi_checker.sv
module ssi_checker
  import ssi_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              start_det,
  input logic              stop_det,
  input logic              cnt_wrap,
  input logic              cnt_tick,
  input logic              cnt_load,
  input logic [CNT_W-1:0]  cnt_val,
  input logic              ovf_f,
  input logic              start_f,
  input logic              stop_f,
  input logic              shift_p,
  input logic              wr_data,
  input logic [DATA_W-1:0] data_q,
  input logic              out_q,
  input logic [1:0]        src,
  input logic              sck_s,
  input logic              sda_s
);
  p_cnt_step_r4: assert property (@(posedge clk) disable iff (rst)
    (cnt_tick && !cnt_load) |=> (cnt_val == $past(cnt_val) + CNT_W'(1)));

  p_wrap_sets_ovf_r5: assert property (@(posedge clk) disable iff (rst)
    cnt_wrap |=> ovf_f);

  p_shift_moves_r3: assert property (@(posedge clk) disable iff (rst)
    (shift_p && !wr_data) |=> (data_q[DATA_W-1:1] == $past(data_q[DATA_W-2:0]))
                              && (data_q[0] == $past(sda_s)));

  p_latch_holds_r6: assert property (@(posedge clk) disable iff (rst)
    (src == CS_EXT_RISE && sck_s) |=> (out_q == $past(out_q)));

  p_start_flag_r8: assert property (@(posedge clk) disable iff (rst)
    start_det |=> start_f);

  p_stop_flag_r9: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> stop_f);
endmodule

bind ser_shift_if ssi_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start_det (start_det),
  .stop_det  (stop_det),
  .cnt_wrap  (cnt_wrap),
  .cnt_tick  (cnt_tick),
  .cnt_load  (wr_stat),
  .cnt_val   (cnt_val),
  .ovf_f     (ovf_f),
  .start_f   (start_f),
  .stop_f    (stop_f),
  .shift_p   (shift_p),
  .wr_data   (wr_data),
  .data_q    (data_q),
  .out_q     (out_q),
  .src       (src_q),
  .sck_s     (pin_s[1]),
  .sda_s     (pin_s[0])
);

// File: tb/tb_ser_shift_if.sv
`timescale 1ns/1ps
module tb_ser_shift_if;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] reg_addr = 2'd0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       tmr_tick_i = 1'b0;
  logic       di_sda_i = 1'b1;
  logic       sck_scl_i = 1'b0;
  logic       do_o, do_oe, sda_oe, scl_oe, irq_start, irq_ovf;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  ser_shift_if #(.DATA_W(8), .CNT_W(4), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tmr_tick_i(tmr_tick_i),
    .di_sda_i(di_sda_i), .sck_scl_i(sck_scl_i), .do_o(do_o), .do_oe(do_oe),
    .sda_oe(sda_oe), .scl_oe(scl_oe), .irq_start(irq_start), .irq_ovf(irq_ovf)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_we = 1'b0;
    @(posedge clk);
    #1 d = reg_rdata;
  endtask

  task automatic pins(input logic di, input logic sck);
    @(negedge clk);
    di_sda_i = di; sck_scl_i = sck;
    cyc(6);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(2'd0, v); chk("R1 data", v, 8'h00);
    rd(2'd1, v); chk("R1 status", v, 8'h00);
    rd(2'd2, v); chk("R1 control", v, 8'h00);
    chk("R1 enables", {do_oe, sda_oe, scl_oe}, 3'b000);
    chk("R1 irqs", {irq_start, irq_ovf}, 2'b00);
  endtask

  task automatic t_soft_shift();
    logic [7:0] v, exp, pat;
    pat = 8'h3C;
    wr(2'd2, 8'h10);
    wr(2'd0, 8'hA5);
    cyc(3);
    chk("R2 do_oe three-wire", do_oe, 1'b1);
    chk("R2 do_o msb", do_o, 1'b1);
    exp = 8'hA5;
    for (int i = 7; i >= 0; i--) begin
      pins(pat[i], 1'b0);
      wr(2'd2, 8'h12);
      cyc(3);
      exp = {exp[6:0], pat[i]};
      chk("R2 do_o follows msb", do_o, exp[7]);
    end
    rd(2'd0, v); chk("R3 shifted byte", v, 8'h3C);
    rd(2'd1, v); chk("R4 count after 8", v, 8'h08);
  endtask

  task automatic t_overflow();
    logic [7:0] v;
    for (int i = 0; i < 8; i++) begin
      wr(2'd2, 8'h12);
      cyc(2);
    end
    rd(2'd1, v); chk("R5 wrap sets flag", v, 8'h40);
    chk("R5 irq masked", irq_ovf, 1'b0);
    wr(2'd2, 8'h50);
    cyc(2);
    chk("R5 irq enabled", irq_ovf, 1'b1);
    wr(2'd1, 8'h40);
    rd(2'd1, v); chk("R5 write one clears", v, 8'h00);
    chk("R5 irq cleared", irq_ovf, 1'b0);
    wr(2'd1, 8'h0D);
    rd(2'd1, v); chk("R4 counter load", v, 8'h0D);
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h10);
  endtask

  task automatic t_ext_rise();
    logic [7:0] v, exp, pat;
    logic held;
    pat = 8'h96;
    pins(1'b1, 1'b0);
    wr(2'd2, 8'h18);
    wr(2'd0, 8'hA5);
    cyc(3);
    exp = 8'hA5;
    for (int i = 7; i >= 0; i--) begin
      pins(pat[i], 1'b0);
      held = exp[7];
      pins(pat[i], 1'b1);
      exp = {exp[6:0], pat[i]};
      rd(2'd0, v); chk("R6 shift on rising edge", v, exp);
      chk("R6 do_o held while clock high", do_o, held);
      pins(pat[i], 1'b0);
      chk("R6 do_o updates after falling edge", do_o, exp[7]);
      if (i == 4) begin
        rd(2'd1, v); chk("R7 both edges counted", v, 8'h08);
      end
    end
    rd(2'd1, v); chk("R7 sixteen edges wrap", v, 8'h40);
    wr(2'd1, 8'h40);
  endtask

  task automatic t_timer();
    logic [7:0] v;
    wr(2'd2, 8'h14);
    wr(2'd0, 8'h00);
    pins(1'b1, 1'b0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); tmr_tick_i = 1'b1;
      @(negedge clk); tmr_tick_i = 1'b0;
      cyc(2);
    end
    rd(2'd0, v); chk("R7 timer shifts", v, 8'h07);
    rd(2'd1, v); chk("R7 timer counts", v, 8'h03);
    wr(2'd2, 8'h16);
    cyc(3);
    rd(2'd0, v); chk("R7 strobe ignored in timer mode", v, 8'h07);
    rd(2'd1, v); chk("R7 strobe not counted in timer mode", v, 8'h03);
    pins(1'b1, 1'b1);
    pins(1'b1, 1'b0);
    rd(2'd1, v); chk("R7 pin edges ignored in timer mode", v, 8'h03);
  endtask

  task automatic t_start_stop();
    logic [7:0] v;
    pins(1'b1, 1'b1);
    wr(2'd1, 8'hE0);
    wr(2'd0, 8'h00);
    wr(2'd2, 8'hA0);
    pins(1'b0, 1'b1);
    rd(2'd1, v); chk("R8 start flag", v, 8'h80);
    chk("R8 irq_start", irq_start, 1'b1);
    chk("R8 clock held low", scl_oe, 1'b1);
    wr(2'd1, 8'h80);
    rd(2'd1, v); chk("R8 start cleared", v, 8'h00);
    chk("R8 clock released", {scl_oe, irq_start}, 2'b00);
    pins(1'b1, 1'b1);
    rd(2'd1, v); chk("R9 stop flag", v, 8'h20);
    chk("R9 no clock hold", scl_oe, 1'b0);
    wr(2'd1, 8'h20);
    rd(2'd1, v); chk("R9 stop cleared", v, 8'h00);
    wr(2'd2, 8'h90);
    pins(1'b0, 1'b1);
    rd(2'd1, v); chk("R8 no start in three-wire", v, 8'h00);
    chk("R8 no irq in three-wire", irq_start, 1'b0);
    pins(1'b1, 1'b1);
    rd(2'd1, v); chk("R9 no stop in three-wire", v, 8'h00);
  endtask

  task automatic t_open_drain();
    logic [7:0] v;
    wr(2'd2, 8'h20);
    wr(2'd0, 8'h00);
    cyc(3);
    chk("R10 pull low on zero", sda_oe, 1'b1);
    chk("R10 do_oe off in two-wire", do_oe, 1'b0);
    wr(2'd0, 8'h80);
    cyc(3);
    chk("R10 release on one", sda_oe, 1'b0);
    wr(2'd1, 8'h0F);
    wr(2'd2, 8'h22);
    cyc(4);
    rd(2'd1, v); chk("R5 overflow in two-wire", v, 8'h40);
    chk("R8 clock held after overflow", scl_oe, 1'b1);
    wr(2'd1, 8'h40);
    cyc(2);
    chk("R8 clock released after clear", scl_oe, 1'b0);
  endtask

  task automatic t_collision();
    logic [7:0] v;
    pins(1'b1, 1'b0);
    wr(2'd0, 8'h80);
    cyc(3);
    pins(1'b0, 1'b0);
    rd(2'd1, v); chk("R11 collision seen", v, 8'h10);
    pins(1'b1, 1'b0);
    rd(2'd1, v); chk("R11 no collision when line high", v, 8'h00);
    wr(2'd0, 8'h00);
    pins(1'b0, 1'b0);
    rd(2'd1, v); chk("R11 no collision when driving low", v, 8'h00);
    pins(1'b1, 1'b0);
  endtask

  initial begin
    cyc(4);
    @(negedge clk) rst = 1'b0;
    cyc(2);
    t_reset();
    t_soft_shift();
    t_overflow();
    t_ext_rise();
    t_timer();
    t_start_stop();
    t_open_drain();
    t_collision();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule